// File: doc/BRIEF.md
# Pin Input Debounce Filter

This block conditions one general-purpose input pin before the pin status and the interrupt sensing logic see it. The raw pin is asynchronous. It is first brought into the core clock domain by a two-stage synchronizer. It then passes through a filter whose hold time is counted in pulses of a slow real-time tick, a single-cycle strobe at about 32.768 kHz.

The hold time is set by two things. A 4-bit count gives the number of units, and two select bits pick the size of one unit: 2, 8, 512 or 2048 ticks. A 2-bit mode field picks how the filter behaves:
- Off: the synchronized level passes straight through.
- Glitch removal: a change in either direction must persist for the whole hold time.
- Keep-low or keep-high: changes toward one level pass at once, and only changes away from that level are filtered.

Keep-low suits high-level interrupt sensing, and keep-high suits low-level sensing. A count of zero marks the hold time as unconfigured, and the pin then passes unfiltered. Software normally programs count 15, the 8-tick unit and glitch removal as its default.

Top module: `gpio_debounce`

## Requirements
- R1: While `rst` is high, `pin_filtered` takes the synchronized pin level and all hold counters return to zero. After reset is released, `pin_filtered` equals the settled pin level.
- R2: With `cfg_mode` = 2'b00 (off), `pin_filtered` follows `pin_raw`, three clock edges after the pin changes.
- R3: With `cfg_mode` = 2'b11 (glitch removal) and a non-zero count, a changed level reaches `pin_filtered` only after the synchronized pin has differed from the output for `cfg_count` × unit tick strobes. This applies to both rising and falling changes.
- R4: In glitch removal mode, a pin pulse whose length is shorter than the hold time never reaches the output. Any return to the output level restarts the hold count from zero.
- R5: The unit size is selected by {`cfg_unit_coarse`, `cfg_unit_fine``}: 00 gives 2 ticks, 01 gives 8 ticks, 10 gives 512 ticks and 11 gives 2048 ticks.
- R6: With `cfg_mode` = 2'b01 (keep-low), a falling change appears three edges after the pin falls. A rising change is filtered as in R3.
- R7: With `cfg_mode` = 2'b10 (keep-high), a rising change appears three edges after the pin rises. A falling change is filtered as in R3.
- R8: A `cfg_count` of zero makes every mode pass the pin through, as in R2.
- R9: The largest count, 15, holds a change back for 15 units.
- R10: `pin_filtered` only ever changes to the synchronized pin value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | 1 | Asynchronous pin level |
| rtc_tick | input | 1 | One-cycle strobe for each slow real-time tick |
| cfg_count | input | 4 | Hold time in units; 0 means unconfigured |
| cfg_unit_fine | input | 1 | Unit select, low bit |
| cfg_unit_coarse | input | 1 | Unit select, high bit |
| cfg_mode | input | 2 | 00 off, 01 keep-low, 10 keep-high, 11 glitch removal |
| pin_filtered | output | 1 | Conditioned pin level |

## Verification
An unfiltered or immediately passed change is due on the third rising edge after the pin moves: two synchronizer stages plus the output register. A filtered change is due on the same edge that samples the final required tick strobe. The bench holds a behavioural model that advances on each rising edge from the same sampled inputs, and it compares the model with the output on every falling edge, so both sides are read half a cycle after they update. The named checks add margins of several tick periods either side of the expected moment, so that they only assert whether a change has or has not happened yet.

// File: rtl/gpio_debounce_pkg.sv
package gpio_debounce_pkg;

    localparam int UNIT_W = 11;

    typedef enum logic [1:0] {
        FILT_OFF       = 2'b00,
        FILT_KEEP_LOW  = 2'b01,
        FILT_KEEP_HIGH = 2'b10,
        FILT_REMOVE    = 2'b11
    } filt_mode_e;

    function automatic logic [UNIT_W-1:0] unit_ticks(input logic coarse, input logic fine);
        case ({coarse, fine})
            2'b00:   unit_ticks = UNIT_W'(2);
            2'b01:   unit_ticks = UNIT_W'(8);
            2'b10:   unit_ticks = UNIT_W'(512);
            default: unit_ticks = UNIT_W'(2048);
        endcase
    endfunction

endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gdb_unit_timer.sv
module gdb_unit_timer
    import gpio_debounce_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    input  logic sel_coarse,
    input  logic sel_fine,
    output logic unit_done
);
    logic [UNIT_W-1:0] len;
    logic [UNIT_W-1:0] ucnt_d, ucnt_q;
    logic              wrap;
    logic              live_q;

    always_comb begin
        len       = unit_ticks(sel_coarse, sel_fine);
        wrap      = (ucnt_q >= len - UNIT_W'(1));
        unit_done = !clr && tick && wrap;
        ucnt_d    = ucnt_q;
        if (clr) begin
            ucnt_d = '0;
        end else if (tick) begin
            ucnt_d = wrap ? '0 : ucnt_q + UNIT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ucnt_q <= '0;
            live_q <= 1'b0;
        end else begin
            ucnt_q <= ucnt_d;
            live_q <= 1'b1;
        end
    end

    // R5: the unit counter only steps by one or returns to zero
    p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
        live_q && (ucnt_q != $past(ucnt_q)) |-> (ucnt_q == '0) || (ucnt_q == $past(ucnt_q) + UNIT_W'(1)));

    // R5: without a tick the unit counter can only be cleared
    p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(!tick) |-> (ucnt_q == $past(ucnt_q)) || (ucnt_q == '0));
endmodule

// File: rtl/gdb_filter.sv
module gdb_filter
    import gpio_debounce_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] count,
    input  logic             unit_done,
    output logic             pending,
    output logic             out
);
    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] pcnt;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic        live_q;
    logic        filt_on, mismatch, fast;

    always_comb begin
        filt_on  = (filt_mode_e'(mode) != FILT_OFF) && (count != '0);
        mismatch = (s != st_q.lvl);
        fast     = ((filt_mode_e'(mode) == FILT_KEEP_LOW)  && !s) ||
                   ((filt_mode_e'(mode) == FILT_KEEP_HIGH) &&  s);
        pending  = filt_on && mismatch && !fast;
        st_d     = st_q;
        if (!filt_on || !mismatch || fast) begin
            st_d.lvl  = s;
            st_d.pcnt = '0;
        end else if (unit_done) begin
            if (st_q.pcnt >= count - CNT_W'(1)) begin
                st_d.lvl  = s;
                st_d.pcnt = '0;
            end else begin
                st_d.pcnt = st_q.pcnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lvl  <= s;
            st_q.pcnt <= '0;
            live_q    <= 1'b0;
        end else begin
            st_q   <= st_d;
            live_q <= 1'b1;
        end
    end

    assign out = st_q.lvl;

    p_follow_sync_r10: assert property (@(posedge clk) disable iff (rst)
        live_q && (st_q.lvl != $past(st_q.lvl)) |-> st_q.lvl == $past(s));

    p_off_pass_r2: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(mode == 2'b00) |-> st_q.lvl == $past(s));

    p_zero_pass_r8: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(count == '0) |-> st_q.lvl == $past(s));

    p_hold_no_unit_r3: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(mode == 2'b11 && count != '0 && !unit_done) |-> st_q.lvl == $past(st_q.lvl));

    p_keep_low_fast_r6: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(mode == 2'b01 && count != '0 && !s) |-> !st_q.lvl);

    p_keep_high_fast_r7: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(mode == 2'b10 && count != '0 && s) |-> st_q.lvl);

    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        live_q && $past(!pending) |-> st_q.pcnt == '0);
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gpio_debounce_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_raw,
    input  logic             rtc_tick,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_unit_fine,
    input  logic             cfg_unit_coarse,
    input  logic [1:0]       cfg_mode,
    output logic             pin_filtered
);
    logic pin_s;
    logic pending;
    logic unit_done;

    gdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .din  (pin_raw),
        .dout (pin_s)
    );

    gdb_unit_timer u_unit (
        .clk        (clk),
        .rst        (rst),
        .clr        (!pending),
        .tick       (rtc_tick),
        .sel_coarse (cfg_unit_coarse),
        .sel_fine   (cfg_unit_fine),
        .unit_done  (unit_done)
    );

    gdb_filter #(.CNT_W(CNT_W)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .s         (pin_s),
        .mode      (cfg_mode),
        .count     (cfg_count),
        .unit_done (unit_done),
        .pending   (pending),
        .out       (pin_filtered)
    );
endmodule

// File: tb/gpio_debounce_tb.sv
module gpio_debounce_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pin_raw = 1'b1;
    logic       rtc_tick = 1'b0;
    logic [3:0] cfg_count = 4'd0;
    logic       cfg_unit_fine = 1'b0;
    logic       cfg_unit_coarse = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic       pin_filtered;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc_n = 0;
    bit    cmp_on = 1'b0;
    string phase = "R1";

    gpio_debounce u_dut (
        .clk             (clk),
        .rst             (rst),
        .pin_raw         (pin_raw),
        .rtc_tick        (rtc_tick),
        .cfg_count       (cfg_count),
        .cfg_unit_fine   (cfg_unit_fine),
        .cfg_unit_coarse (cfg_unit_coarse),
        .cfg_mode        (cfg_mode),
        .pin_filtered    (pin_filtered)
    );

    always #4 clk = ~clk;

    // Behavioural reference: queue of synchronizer stages and a tick tally
    logic sync_q[$] = '{1'b0, 1'b0};
    logic m_out = 1'b0;
    int   m_ticks = 0;

    function automatic int unit_of(input logic c, input logic f);
        if (!c && !f) return 2;
        if (!c &&  f) return 8;
        if ( c && !f) return 512;
        return 2048;
    endfunction

    always @(posedge clk) begin
        logic sv;
        sv = sync_q[1];
        if (rst || cfg_mode == 2'b00 || cfg_count == 0) begin
            m_out = sv; m_ticks = 0;
        end else if (sv == m_out) begin
            m_ticks = 0;
        end else if ((cfg_mode == 2'b01 && !sv) || (cfg_mode == 2'b10 && sv)) begin
            m_out = sv; m_ticks = 0;
        end else if (rtc_tick) begin
            m_ticks++;
            if (m_ticks >= int'(cfg_count) * unit_of(cfg_unit_coarse, cfg_unit_fine)) begin
                m_out = sv; m_ticks = 0;
            end
        end
        sync_q.push_front(pin_raw);
        void'(sync_q.pop_back());
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", tag, act, exp, cyc_n);
        end
    endtask

    always @(negedge clk) begin
        cyc_n++;
        rtc_tick <= (cyc_n % 3 == 0);
        if (cmp_on && !rst) chk(pin_filtered, m_out, {phase, " model"});
    end

    always @(posedge clk) begin
        if (cyc_n > 150000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] m, input logic [3:0] c, input logic co, input logic fi);
        cfg_mode = 2'b00;
        wait_n(5);
        cfg_mode = m; cfg_count = c; cfg_unit_coarse = co; cfg_unit_fine = fi;
        wait_n(2);
    endtask

    initial begin
        wait_n(8);
        rst = 1'b0;
        wait_n(1);
        chk(pin_filtered, 1'b1, "R1 reset level");
        cmp_on = 1'b1;

        // R2: off mode pass-through, three-edge latency
        phase = "R2";
        setup(2'b00, 4'd5, 1'b0, 1'b0);
        pin_raw = 1'b0; wait_n(2);
        chk(pin_filtered, 1'b1, "R2 before third edge");
        wait_n(1);
        chk(pin_filtered, 1'b0, "R2 after third edge");
        pin_raw = 1'b1; wait_n(3);
        chk(pin_filtered, 1'b1, "R2 rising");

        // R8: zero count passes in a filtering mode
        phase = "R8";
        setup(2'b11, 4'd0, 1'b0, 1'b0);
        pin_raw = 1'b0; wait_n(3);
        chk(pin_filtered, 1'b0, "R8 zero count pass");

        // R3: glitch removal, both directions, 3 units of 2 ticks
        phase = "R3";
        setup(2'b11, 4'd3, 1'b0, 1'b0);
        pin_raw = 1'b1; wait_n(10);
        chk(pin_filtered, 1'b0, "R3 rising held back");
        wait_n(30);
        chk(pin_filtered, 1'b1, "R3 rising passed");
        pin_raw = 1'b0; wait_n(10);
        chk(pin_filtered, 1'b1, "R3 falling held back");
        wait_n(30);
        chk(pin_filtered, 1'b0, "R3 falling passed");

        // R4: short pulses and restart of the hold count
        phase = "R4";
        pin_raw = 1'b1; wait_n(9);
        pin_raw = 1'b0; wait_n(30);
        chk(pin_filtered, 1'b0, "R4 short pulse removed");
        pin_raw = 1'b1; wait_n(9);
        pin_raw = 1'b0; wait_n(2);
        pin_raw = 1'b1; wait_n(9);
        pin_raw = 1'b0; wait_n(30);
        chk(pin_filtered, 1'b0, "R4 restart after return");

        // R5: each unit size with a count of one
        phase = "R5";
        for (int k = 0; k < 4; k++) begin
            logic co, fi, lv;
            int u;
            co = k[1]; fi = k[0];
            u = unit_of(co, fi);
            setup(2'b11, 4'd1, co, fi);
            lv = pin_filtered;
            pin_raw = !lv;
            wait_n(3 * u - 6);
            chk(pin_filtered, lv, "R5 unit not yet elapsed");
            wait_n(16);
            chk(pin_filtered, !lv, "R5 unit elapsed");
        end

        // R9: maximum count of 15 with the 2-tick unit
        phase = "R9";
        setup(2'b11, 4'd15, 1'b0, 1'b0);
        pin_raw = !pin_filtered;
        wait_n(84);
        chk(pin_filtered, !pin_raw, "R9 still held at 14 units");
        wait_n(16);
        chk(pin_filtered, pin_raw, "R9 passed at 15 units");

        // R6: keep-low mode
        phase = "R6";
        setup(2'b00, 4'd3, 1'b0, 1'b0);
        pin_raw = 1'b1; wait_n(4);
        setup(2'b01, 4'd3, 1'b0, 1'b0);
        pin_raw = 1'b0; wait_n(3);
        chk(pin_filtered, 1'b0, "R6 falling immediate");
        pin_raw = 1'b1; wait_n(8);
        pin_raw = 1'b0; wait_n(20);
        chk(pin_filtered, 1'b0, "R6 high pulse removed");
        pin_raw = 1'b1; wait_n(40);
        chk(pin_filtered, 1'b1, "R6 rising after hold");

        // R7: keep-high mode
        phase = "R7";
        setup(2'b10, 4'd3, 1'b0, 1'b0);
        pin_raw = 1'b0; wait_n(8);
        pin_raw = 1'b1; wait_n(20);
        chk(pin_filtered, 1'b1, "R7 low pulse removed");
        pin_raw = 1'b0; wait_n(40);
        chk(pin_filtered, 1'b0, "R7 falling after hold");
        pin_raw = 1'b1; wait_n(3);
        chk(pin_filtered, 1'b1, "R7 rising immediate");

        // R1: reset reloads the synchronized level
        phase = "R1";
        cmp_on = 1'b0;
        pin_raw = 1'b0; rst = 1'b1; wait_n(4);
        rst = 1'b0; wait_n(1);
        chk(pin_filtered, 1'b0, "R1 reset takes synced pin");
        cmp_on = 1'b1;
        wait_n(5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule